// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Controller

This block holds the digital state of a two-channel voltage-output converter. A serial receiver upstream assembles a 24-bit command word and presents it with a single-cycle valid pulse. The controller keeps one staging buffer and one output register per channel. Each holds a 16-bit code and a 2-bit power mode. A word always writes the staging buffer it selects, and it may also copy either or both buffers into their output registers. A host can therefore stage both channels and then switch them together. The output registers drive the analog string and the output stage, which sit outside this block.

Power-down commands travel through the same staging path as data. A channel changes power state only when it is loaded. A channel returns to normal operation only after its buffer has received a mode-00 data write and the channel is then loaded. Each channel gives a one-cycle update strobe whenever it is loaded. A word with nonzero reserved bits is rejected as a whole and sets a sticky error flag.

Top module: `dac_pair_ctrl`

## Requirements
- R1: After reset, both output codes are 0, both output power modes are 00, both update strobes are 0 and the error flag is 0. Both staging buffers also hold code 0 and mode 00.
- R2: Command word field layout:
  - bits 23:22: reserved, must be zero.
  - bit 21: load channel B.
  - bit 20: load channel A.
  - bit 19: ignored.
  - bit 18: buffer select (0 = A, 1 = B).
  - bits 17:16: power mode.
  - bits 15:0: code.
- R3: An accepted word whose mode field is 00 stores the code and mode 00 in the selected buffer. The output registers do not change unless a load flag is set.
- R4: An accepted word whose mode field is nonzero stores that mode in the selected buffer and leaves that buffer's code unchanged. The word's code bits have no effect.
- R5: A set load flag copies that channel's buffer, code and mode, into its output register. The outputs show the new value in the cycle after the clock edge that accepts the word.
- R6: Within one word, the buffer write takes effect before the load. Loading the channel just written therefore delivers the word's new contents.
- R7: With both load flags set, both channels update on the same clock edge.
- R8: A channel's update strobe is high for exactly the cycle after each edge that loads it, and low in every other cycle.
- R9: A word with either reserved bit set changes no buffer, no output and no strobe. It sets the error flag, which stays set until reset.
- R10: Bit 19 has no effect on any state or output.
- R11: Power mode codes: 00 is normal, 01 is about 1 kΩ to ground, 10 is about 100 kΩ to ground, and 11 is high-impedance. A powered-down channel keeps its output mode until a load arrives. A mode-00 write to its buffer without a load leaves the output powered down.
- R12: While cmd_valid is low, cmd_word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word valid for this cycle |
| cmd_word | input | 24 | Decoded command word |
| code_a | output | 16 | Active code of channel A |
| code_b | output | 16 | Active code of channel B |
| pmode_a | output | 2 | Active power mode of channel A |
| pmode_b | output | 2 | Active power mode of channel B |
| upd_a | output | 1 | Channel A update strobe |
| upd_b | output | 1 | Channel B update strobe |
| cmd_err | output | 1 | Sticky reserved-field error flag |

## Verification
A buffer write and a load of the same channel can fall on the same clock edge. A single word can also load both channels while writing one of them. The bench sweeps every combination of the two load flags, the select bit, all four power modes and bit 19 against varying codes. It predicts each buffer and output register arithmetically and compares all outputs one cycle after each word. A loaded channel that still showed its old buffer contents, or a missing partner-channel update, is flagged as a mismatch.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    parameter int DPC_CODE_W = 16;
    parameter int DPC_MODE_W = 2;
    parameter int DPC_NUM_CH = 2;
    parameter int DPC_CTRL_W = 8;

    localparam int WORD_W   = DPC_CODE_W + DPC_CTRL_W;
    localparam int MODE_LSB = DPC_CODE_W;
    localparam int SEL_BIT  = DPC_CODE_W + DPC_MODE_W;
    localparam int LD_LSB   = SEL_BIT + 2;
    localparam int RSV_LSB  = LD_LSB + DPC_NUM_CH;

    localparam logic [DPC_MODE_W-1:0] MODE_NORMAL = '0;

    typedef struct packed {
        logic [DPC_MODE_W-1:0] mode;
        logic [DPC_CODE_W-1:0] code;
    } chan_t;

    typedef struct packed {
        logic                  accept;
        logic                  reject;
        logic [DPC_NUM_CH-1:0] ld;
        logic                  sel;
        logic [DPC_MODE_W-1:0] mode;
        logic [DPC_CODE_W-1:0] code;
    } cmd_t;

    typedef struct packed {
        chan_t stage;
        chan_t live;
        logic  upd;
    } ch_state_t;
endpackage

// File: rtl/dpc_decode.sv
module dpc_decode
    import dpc_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output cmd_t              cmd
);
    logic rsv_set;

    always_comb begin
        rsv_set    = |word[WORD_W-1:RSV_LSB];
        cmd.accept = valid && !rsv_set;
        cmd.reject = valid && rsv_set;
        cmd.ld     = word[LD_LSB +: DPC_NUM_CH];
        cmd.sel    = word[SEL_BIT];
        cmd.mode   = word[MODE_LSB +: DPC_MODE_W];
        cmd.code   = word[DPC_CODE_W-1:0];
    end
endmodule

// File: rtl/dpc_channel.sv
module dpc_channel
    import dpc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DPC_MODE_W-1:0] wr_mode,
    input  logic [DPC_CODE_W-1:0] wr_code,
    input  logic                  ld_en,
    output chan_t                 live,
    output logic                  upd
);
    ch_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (wr_en) begin
            st_d.stage.mode = wr_mode;
            if (wr_mode == MODE_NORMAL) begin
                st_d.stage.code = wr_code;
            end
        end
        // load copies the already-updated staging value
        if (ld_en) begin
            st_d.live = st_d.stage;
            st_d.upd  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live = st_q.live;
    assign upd  = st_q.upd;
endmodule

// File: rtl/dac_pair_ctrl.sv
module dac_pair_ctrl
    import dpc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [WORD_W-1:0]     cmd_word,
    output logic [DPC_CODE_W-1:0] code_a,
    output logic [DPC_CODE_W-1:0] code_b,
    output logic [DPC_MODE_W-1:0] pmode_a,
    output logic [DPC_MODE_W-1:0] pmode_b,
    output logic                  upd_a,
    output logic                  upd_b,
    output logic                  cmd_err
);
    cmd_t                  cmd;
    chan_t                 live [DPC_NUM_CH];
    logic [DPC_NUM_CH-1:0] upd;
    logic                  err_d, err_q;

    dpc_decode i_decode (
        .valid (cmd_valid),
        .word  (cmd_word),
        .cmd   (cmd)
    );

    for (genvar ch = 0; ch < DPC_NUM_CH; ch++) begin : g_ch
        logic wr_en, ld_en;
        always_comb begin
            wr_en = cmd.accept && (int'(cmd.sel) == ch);
            ld_en = cmd.accept && cmd.ld[ch];
        end
        dpc_channel i_channel (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_mode (cmd.mode),
            .wr_code (cmd.code),
            .ld_en   (ld_en),
            .live    (live[ch]),
            .upd     (upd[ch])
        );
    end

    always_comb begin
        err_d = err_q || cmd.reject;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign code_a  = live[0].code;
    assign pmode_a = live[0].mode;
    assign code_b  = live[1].code;
    assign pmode_b = live[1].mode;
    assign upd_a   = upd[0];
    assign upd_b   = upd[1];
    assign cmd_err = err_q;
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker
    import dpc_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid,
    input logic [WORD_W-1:0]     cmd_word,
    input logic [DPC_CODE_W-1:0] code_a,
    input logic [DPC_CODE_W-1:0] code_b,
    input logic [DPC_MODE_W-1:0] pmode_a,
    input logic [DPC_MODE_W-1:0] pmode_b,
    input logic                  upd_a,
    input logic                  upd_b,
    input logic                  cmd_err
);
    logic rsv_hit, good;
    assign rsv_hit = |cmd_word[WORD_W-1:RSV_LSB];
    assign good    = cmd_valid && !rsv_hit;

    assert_out_a_only_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(code_a) && $stable(pmode_a)) |-> upd_a);
    assert_out_b_only_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(code_b) && $stable(pmode_b)) |-> upd_b);
    assert_dual_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (good && cmd_word[LD_LSB] && cmd_word[LD_LSB+1]) |=> (upd_a && upd_b));
    assert_idle_no_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!upd_a && !upd_b));
    assert_reject_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && rsv_hit) |=> (cmd_err && !upd_a && !upd_b && $stable(code_a) && $stable(code_b)));
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);
    assert_strobe_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_word[LD_LSB]) |=> !upd_a);
endmodule

bind dac_pair_ctrl dpc_checker i_dpc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .code_a    (code_a),
    .code_b    (code_b),
    .pmode_a   (pmode_a),
    .pmode_b   (pmode_b),
    .upd_a     (upd_a),
    .upd_b     (upd_b),
    .cmd_err   (cmd_err)
);

// File: tb/test_dac_pair_ctrl.sv
module test_dac_pair_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [23:0] cmd_word = '0;
    logic [15:0] code_a, code_b;
    logic [1:0]  pmode_a, pmode_b;
    logic        upd_a, upd_b, cmd_err;

    int n_chk = 0;
    int n_fail = 0;

    // bench model
    logic [15:0] m_bcode [2];
    logic [1:0]  m_bmode [2];
    logic [15:0] m_ocode [2];
    logic [1:0]  m_omode [2];
    logic [1:0]  m_upd;
    logic        m_err;

    always #2.5 clk = ~clk;

    dac_pair_ctrl i_dac_pair_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .code_a(code_a), .code_b(code_b), .pmode_a(pmode_a), .pmode_b(pmode_b),
        .upd_a(upd_a), .upd_b(upd_b), .cmd_err(cmd_err)
    );

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_bcode[c] = '0; m_bmode[c] = '0; m_ocode[c] = '0; m_omode[c] = '0;
        end
        m_upd = '0;
        m_err = 1'b0;
    endtask

    task automatic model_apply(input logic [23:0] w);
        int s;
        m_upd = '0;
        if (w[23:22] != 2'b00) begin
            m_err = 1'b1;
            return;
        end
        s = int'(w[18]);
        m_bmode[s] = w[17:16];
        if (w[17:16] == 2'b00) m_bcode[s] = w[15:0];
        for (int c = 0; c < 2; c++) begin
            if (w[20+c]) begin
                m_ocode[c] = m_bcode[c];
                m_omode[c] = m_bmode[c];
                m_upd[c]   = 1'b1;
            end
        end
    endtask

    task automatic check(input string tag);
        logic [40:0] act, exp;
        act = {code_a, code_b, pmode_a, pmode_b, upd_a, upd_b, cmd_err};
        exp = {m_ocode[0], m_ocode[1], m_omode[0], m_omode[1], m_upd[0], m_upd[1], m_err};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one word; sample outputs one cycle later, away from the edge
    task automatic send(input logic [23:0] w, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = 24'hA5A5A5;
        model_apply(w);
        check(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            m_upd = '0;
            check(tag);
        end
    endtask

    initial begin
        #(5 * 20000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R12: garbage with valid low does nothing
        cmd_word = 24'h33FFFF;
        idle(3, "R12");

        // R2 field sweep: load flags, select, mode, bit 19
        for (int i = 0; i < 64; i++) begin
            logic [23:0] w;
            string tag;
            w = {2'b00, i[5:4], i[0], i[3], i[2:1], 16'(i * 16'h2B3D + 16'h0F11)};
            if (w[21] && w[20]) tag = "R7";
            else if (w[20 + int'(w[18])]) tag = "R6";
            else if (w[21] || w[20]) tag = "R5";
            else if (w[17:16] != 2'b00) tag = "R4";
            else tag = "R3";
            send(w, tag);
            if (i % 8 == 7) idle(1, "R8");
        end

        // R10: bit 19 flipped gives the same result
        send(24'h100000 | 24'h00BEEF, "R10");
        send(24'h180000 | 24'h001234, "R10");

        // R11: power down A to high-Z, then data without load keeps it down
        send({8'b0001_0011, 16'hFFFF}, "R11");
        send({8'b0000_0000, 16'h4321}, "R11");
        send({8'b0000_0100, 16'h0000}, "R11");
        send({8'b0001_0000, 16'h8000}, "R11");
        // simultaneous sequence: stage A, then B with both loads
        send({8'b0000_0000, 16'h1111}, "R3");
        send({8'b0011_0100, 16'h2222}, "R7");
        idle(1, "R8");

        // R9: reserved bits reject and stick
        send({8'b1011_0000, 16'h7777}, "R9");
        send({8'b0101_0101, 16'h6666}, "R9");
        send({8'b0010_0110, 16'h0000}, "R9");
        idle(2, "R9");

        // reset clears the sticky flag and all state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check("R1");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule